// File: doc/BRIEF.md
# Serial NOR Flash Program and Erase Sequencer

This block carries out whole erase and program operations on a serial NOR flash device through a byte-wide SPI mode 0 shifter. A host pulses `start` with a 24-bit flash address, a byte length and a two-bit operation select. The block then runs every command frame the operation needs, with no further help from the host. It opens with write-enable and checks the device status register, sends the erase or program command, waits out each busy period, and closes with write-disable. When the operation is over it pulses `done`. A request it cannot run gets `done` and `err` together, and the flash is not touched.

Two erase sizes and two program styles are available. An erase longer than one sector is split into separate single-sector operations, and the address advances by one sector for each. Page programming draws bytes from a valid/ready stream. When the address reaches a page-chunk boundary, the block closes the frame, waits until the device is idle, enables writing again and reopens the frame at the new address. Word programming sends two bytes per frame. After the first frame it repeats only the opcode, with no address and no new write-enable.

Top module: `spi_flash_seq`

## Requirements
- R1: While `rst_n` is low and after its release, `spi_cs_n` is 1, `spi_sclk` is 0, and `done`, `err` and `wr_ready` are 0.
- R2: `op_sel` picks the operation and its opcode: 0 erases a 4096-byte sector with 0x20, 1 erases a 1024-byte sector with 0xD7, 2 is page program with 0x02, and 3 is word program with 0xAD.
- R3: Every operation, and every re-enable inside one, first sends a one-byte frame 0x06. It then sends read-status frames (0x05 followed by one dummy byte 0x00) until bits[1:0] of the returned status equal 2'b10. The higher status bits are ignored.
- R4: After each erase or program frame, read-status frames repeat until status bit 0 is 0. The block then sends a one-byte frame 0x04, polls bit 0 the same way and pulses `done` for one cycle with `spi_cs_n` high. The polls have no retry limit.
- R5: An erase frame, and any program frame that carries an address, sends the opcode followed by the three address bytes, most significant first. Every byte on `spi_mosi` goes out MSB first, changes while `spi_sclk` is low and is sampled on its rising edge.
- R6: An erase of `len` bytes runs ceil(`len`/sector) complete sequences (write-enable, polls, erase, polls, write-disable, poll). Their addresses are `addr`, `addr`+sector, and so on.
- R7: In page mode the data bytes follow the address in the same frame. When the next byte address is a multiple of `CHUNK` and bytes remain, the frame closes. Busy is polled, the write-enable sequence runs, and a new frame 0x02 with the new address continues the data. A transfer that ends exactly on a boundary does not reopen.
- R8: In word mode the first frame is 0xAD, three address bytes and two data bytes. After its busy poll, each later pair goes in a frame of 0xAD and two data bytes, with no address and no write-enable in between.
- R9: Between any two frames `spi_cs_n` stays high for at least two clock cycles, and `spi_sclk` is 0 whenever `spi_cs_n` is high.
- R10: A request with `len` 0, or with an odd `len` in word mode, gives `done` and `err` high together in the cycle after `start` is taken, and produces no frame.
- R11: A data byte is taken only in a cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` is high only inside an open program frame. Stalls on `wr_valid` neither lose nor repeat bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, taken while idle |
| op_sel | input | 2 | Operation select (see R2) |
| addr | input | 24 | Flash byte address |
| len | input | LEN_W | Byte count |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data byte present |
| wr_ready | output | 1 | Program data byte taken this cycle when valid |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Request rejected, high with `done` |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
A rejected request raises `done` and `err` one clock after the edge that samples `start`. The bench reads them at the falling edge that follows that edge. A completed operation raises `done` one clock after the last status bit is shifted in, and chip select has already gone high on that edge. The bench therefore waits for `done` at falling edges before it compares the full frame log. That log is collected by a behavioural flash model at each rising edge of chip select, and its busy and write-enable bits change only between frames. As a result, the expected number of polls is fixed for each operation.

// File: rtl/spi_flash_seq.sv
module spi_flash_seq #(
  parameter int LEN_W      = 16,
  parameter int CHUNK      = 256,
  parameter int BIG_SECT   = 4096,
  parameter int SMALL_SECT = 1024,
  parameter int GAP        = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op_sel,
  input  logic [23:0]      addr,
  input  logic [LEN_W-1:0] len,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic             done,
  output logic             err,
  output logic             spi_sclk,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam int CW = $clog2(CHUNK);
  localparam int GW = $clog2(GAP + 1);

  typedef enum logic [2:0] {P_IDLE, P_WREN, P_WEL, P_CMD, P_DATA, P_BUSY, P_WRDI, P_FIN} ph_t;

  ph_t             ph;
  logic [1:0]      k;
  logic [1:0]      op_q;
  logic [23:0]     a_q;
  logic [LEN_W-1:0] rem;
  logic            use_addr, wpair;
  logic [7:0]      sh_tx, sh_rx, tx_byte, opcode;
  logic [3:0]      sh_cnt;
  logic            sh_busy;
  logic [GW-1:0]   gap;
  logic            idle;

  wire is_erase = ~op_q[1];
  wire is_word  = (op_q == 2'b11);
  wire [LEN_W-1:0] sect = op_q[0] ? LEN_W'(SMALL_SECT) : LEN_W'(BIG_SECT);
  wire last     = sh_busy && (sh_cnt == 4'd15);
  wire cmd_ph   = (ph != P_IDLE) && (ph != P_DATA);
  wire load_cmd = cmd_ph && !sh_busy && (gap == '0);
  wire load_dat = wr_valid && wr_ready;

  assign idle     = (ph == P_IDLE);
  assign wr_ready = (ph == P_DATA) && !sh_busy;
  assign spi_sclk = sh_busy & sh_cnt[0];
  assign spi_mosi = sh_tx[7];

  always_comb begin
    case (op_q)
      2'd0:    opcode = 8'h20;
      2'd1:    opcode = 8'hD7;
      2'd2:    opcode = 8'h02;
      default: opcode = 8'hAD;
    endcase
    case (ph)
      P_WREN:  tx_byte = 8'h06;
      P_WRDI:  tx_byte = 8'h04;
      P_CMD:   case (k)
                 2'd0:    tx_byte = opcode;
                 2'd1:    tx_byte = a_q[23:16];
                 2'd2:    tx_byte = a_q[15:8];
                 default: tx_byte = a_q[7:0];
               endcase
      P_DATA:  tx_byte = wr_data;
      default: tx_byte = (k == 2'd0) ? 8'h05 : 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= P_IDLE; k <= '0; op_q <= '0; a_q <= '0; rem <= '0;
      use_addr <= 1'b0; wpair <= 1'b0; sh_tx <= '0; sh_rx <= '0;
      sh_cnt <= '0; sh_busy <= 1'b0; gap <= '0; spi_cs_n <= 1'b1;
      done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (gap != '0) gap <= gap - 1'b1;
      if (sh_busy) begin
        sh_cnt <= sh_cnt + 1'b1;
        if (!sh_cnt[0]) sh_rx <= {sh_rx[6:0], spi_miso};
        else if (sh_cnt != 4'd15) sh_tx <= {sh_tx[6:0], 1'b0};
      end
      if (load_cmd || load_dat) begin
        sh_tx <= tx_byte; sh_cnt <= '0; sh_busy <= 1'b1; spi_cs_n <= 1'b0;
      end
      if (load_dat) begin
        a_q <= a_q + 24'd1; rem <= rem - 1'b1; wpair <= ~wpair;
      end
      if (idle && start) begin
        if (len == '0 || (op_sel == 2'b11 && len[0])) begin
          done <= 1'b1; err <= 1'b1;
        end else begin
          op_q <= op_sel; a_q <= addr; rem <= len; use_addr <= 1'b1;
          ph <= P_WREN; k <= '0;
        end
      end
      if (last) begin
        sh_busy <= 1'b0;
        k <= k + 1'b1;
        case (ph)
          P_WREN: begin spi_cs_n <= 1'b1; gap <= GW'(GAP); k <= '0; ph <= P_WEL; end
          P_WRDI: begin spi_cs_n <= 1'b1; gap <= GW'(GAP); k <= '0; ph <= P_FIN; end
          P_WEL: if (k == 2'd1) begin
            spi_cs_n <= 1'b1; gap <= GW'(GAP); k <= '0;
            if (sh_rx[1:0] == 2'b10) begin ph <= P_CMD; use_addr <= 1'b1; end
          end
          P_BUSY: if (k == 2'd1) begin
            spi_cs_n <= 1'b1; gap <= GW'(GAP); k <= '0;
            if (!sh_rx[0]) begin
              if (is_erase) begin
                ph <= P_WRDI; a_q <= a_q + 24'(sect);
                rem <= (rem > sect) ? rem - sect : '0;
              end else if (rem == '0) ph <= P_WRDI;
              else if (is_word) begin ph <= P_CMD; use_addr <= 1'b0; end
              else ph <= P_WREN;
            end
          end
          P_FIN: if (k == 2'd1) begin
            spi_cs_n <= 1'b1; gap <= GW'(GAP); k <= '0;
            if (!sh_rx[0]) begin
              if (rem != '0) ph <= P_WREN;
              else begin ph <= P_IDLE; done <= 1'b1; end
            end
          end
          P_CMD: if (k == 2'd3 || !use_addr) begin
            k <= '0;
            if (is_erase) begin spi_cs_n <= 1'b1; gap <= GW'(GAP); ph <= P_BUSY; end
            else begin ph <= P_DATA; wpair <= 1'b0; end
          end
          P_DATA: if (rem == '0 || (!is_word && a_q[CW-1:0] == '0) || (is_word && !wpair)) begin
            spi_cs_n <= 1'b1; gap <= GW'(GAP); k <= '0; ph <= P_BUSY;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module spi_flash_seq_chk #(parameter int LEN_W = 16) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LEN_W-1:0] len,
  input logic             idle,
  input logic             done,
  input logic             err,
  input logic             spi_cs_n,
  input logic             spi_sclk,
  input logic             wr_ready
);
  assert_sclk_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  assert_cs_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> spi_cs_n);
  assert_ready_in_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !spi_cs_n);
  assert_err_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  assert_reject_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start && len == '0) |=> (done && err));
  assert_done_cs_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> spi_cs_n);
endmodule

bind spi_flash_seq spi_flash_seq_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .len(len), .idle(idle),
  .done(done), .err(err), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
  .wr_ready(wr_ready)
);

// File: tb/spi_flash_seq_tb.sv
module spi_flash_seq_tb;
  localparam int CH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        start = 1'b0;
  logic [1:0]  op_sel = '0;
  logic [23:0] addr = '0;
  logic [15:0] len = '0;
  logic [7:0]  wr_data = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready, done, err, spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  spi_flash_seq #(.CHUNK(CH)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .addr(addr),
    .len(len), .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .done(done), .err(err), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_run = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural flash
  int busy_polls = 0, wel_dly = 0;
  bit wel = 1'b0;
  logic [7:0] bitcnt = '0, cur = '0;
  logic [7:0] fb [0:23];
  int fcnt = 0;
  logic [7:0] lg_b [0:95][0:23];
  int lg_len [0:95];
  int nlog = 0;
  wire [7:0] status = {6'b0, wel && (wel_dly == 0), busy_polls > 0};
  assign spi_miso = status[~bitcnt[2:0]];

  always @(negedge spi_cs_n) begin bitcnt = '0; fcnt = 0; end
  always @(posedge spi_sclk) begin
    cur = {cur[6:0], spi_mosi};
    if (bitcnt[2:0] == 3'd7 && fcnt < 24) begin fb[fcnt] = cur; fcnt++; end
    bitcnt = bitcnt + 8'd1;
  end
  always @(posedge spi_cs_n) if (rst_n && fcnt > 0) begin
    if (nlog < 96) begin
      lg_len[nlog] = fcnt;
      for (int i = 0; i < fcnt; i++) lg_b[nlog][i] = fb[i];
      nlog++;
    end
    case (fb[0])
      8'h06: begin wel = 1'b1; wel_dly = 1; end
      8'h04: wel = 1'b0;
      8'h05: begin if (busy_polls > 0) busy_polls--; if (wel_dly > 0) wel_dly--; end
      8'h20, 8'hD7, 8'h02: begin busy_polls = 2; wel = 1'b0; end
      8'hAD: busy_polls = 2;
      default: ;
    endcase
    fcnt = 0;
  end

  // data source
  logic [7:0] feed [0:31];
  int feed_len = 0, fidx = 0, cyc = 0;
  bit stall = 1'b0;
  always @(negedge clk) begin
    cyc++;
    wr_valid = (fidx < feed_len) && (!stall || (cyc % 3) != 0);
    wr_data  = (fidx < feed_len) ? feed[fidx] : 8'h00;
  end

  int tot = 0, hi = 0, min_gap = 1000;
  bit framed = 1'b0;
  always @(posedge clk) begin
    if (wr_valid && wr_ready) fidx <= fidx + 1;
    if (spi_cs_n) hi++;
    else begin
      if (hi > 0 && framed && hi < min_gap) min_gap = hi;
      framed = 1'b1; hi = 0;
    end
    tot++;
    if (tot > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual=hang expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  // expected frames
  logic [7:0] ex_bt [0:95][0:23];
  int ex_len [0:95];
  int nexp = 0;
  task automatic ex_new(); ex_len[nexp] = 0; nexp++; endtask
  task automatic ex_b(input logic [7:0] b);
    ex_bt[nexp-1][ex_len[nexp-1]] = b; ex_len[nexp-1]++;
  endtask
  task automatic ex_poll(input int n);
    repeat (n) begin ex_new(); ex_b(8'h05); ex_b(8'h00); end
  endtask
  task automatic ex_wren(); ex_new(); ex_b(8'h06); ex_poll(2); endtask
  task automatic ex_wrdi(); ex_new(); ex_b(8'h04); ex_poll(1); endtask
  task automatic ex_cmd(input logic [7:0] op, input logic [23:0] a);
    ex_new(); ex_b(op); ex_b(a[23:16]); ex_b(a[15:8]); ex_b(a[7:0]);
  endtask

  task automatic clear(input int n, input bit st);
    nlog = 0; nexp = 0; framed = 1'b0; hi = 0;
    for (int i = 0; i < n; i++) feed[i] = 8'hA0 + 8'(i);
    fidx = 0; feed_len = n; stall = st;
  endtask

  task automatic compare(input string req);
    int bad = -1;
    chk(nlog == nexp, req, "frame count", nlog, nexp);
    for (int i = 0; i < nexp && i < nlog; i++) begin
      if (bad < 0 && lg_len[i] != ex_len[i]) bad = i;
      for (int j = 0; j < ex_len[i] && j < lg_len[i]; j++)
        if (bad < 0 && lg_b[i][j] != ex_bt[i][j]) bad = i;
    end
    chk(bad < 0, req, "first mismatching frame", bad < 0 ? 0 : bad, 0);
  endtask

  task automatic run_op(input logic [1:0] m, input logic [23:0] a,
                        input logic [15:0] l, output bit e);
    @(negedge clk); start = 1'b1; op_sel = m; addr = a; len = l;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    e = err;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1", "cs/sclk in reset", {spi_cs_n, spi_sclk}, 2'b10);
    chk(done == 1'b0 && err == 1'b0 && wr_ready == 1'b0, "R1", "done/err/ready in reset",
        {done, err, wr_ready}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0 && done == 1'b0, "R1", "state after release",
        {spi_cs_n, spi_sclk, done}, 3'b100);
  endtask

  task automatic t_erase_big();
    bit e;
    clear(0, 0);
    ex_wren(); ex_cmd(8'h20, 24'h123456); ex_poll(3); ex_wrdi();
    run_op(2'd0, 24'h123456, 16'd4096, e);
    chk(e == 1'b0, "R4", "err on 4K erase", e, 0);
    compare("R2 R3 R4 R5 4K erase");
  endtask

  task automatic t_erase_multi();
    bit e;
    clear(0, 0);
    for (int s = 0; s < 3; s++) begin
      ex_wren(); ex_cmd(8'hD7, 24'h000400 + 24'(s * 1024)); ex_poll(3); ex_wrdi();
    end
    run_op(2'd1, 24'h000400, 16'd2500, e);
    compare("R6 multi-sector 1K erase");
  endtask

  task automatic t_page();
    bit e;
    clear(20, 1);
    ex_wren(); ex_cmd(8'h02, 24'h00000C);
    for (int i = 0; i < 4; i++) ex_b(8'hA0 + 8'(i));
    ex_poll(3); ex_wren(); ex_cmd(8'h02, 24'h000010);
    for (int i = 4; i < 20; i++) ex_b(8'hA0 + 8'(i));
    ex_poll(3); ex_wrdi();
    run_op(2'd2, 24'h00000C, 16'd20, e);
    compare("R7 page program across boundary");
    chk(fidx == 20, "R11", "bytes taken with stalls", fidx, 20);
    chk(min_gap >= 2, "R9", "min cs high cycles", min_gap, 2);
  endtask

  task automatic t_page_exact();
    bit e;
    clear(16, 0);
    ex_wren(); ex_cmd(8'h02, 24'h000000);
    for (int i = 0; i < 16; i++) ex_b(8'hA0 + 8'(i));
    ex_poll(3); ex_wrdi();
    run_op(2'd2, 24'h000000, 16'd16, e);
    compare("R7 page program ending on boundary");
    chk(fidx == 16, "R11", "bytes taken", fidx, 16);
  endtask

  task automatic t_word();
    bit e;
    clear(6, 1);
    ex_wren(); ex_cmd(8'hAD, 24'h000100); ex_b(8'hA0); ex_b(8'hA1); ex_poll(3);
    ex_new(); ex_b(8'hAD); ex_b(8'hA2); ex_b(8'hA3); ex_poll(3);
    ex_new(); ex_b(8'hAD); ex_b(8'hA4); ex_b(8'hA5); ex_poll(3);
    ex_wrdi();
    run_op(2'd3, 24'h000100, 16'd6, e);
    compare("R8 word program");
    chk(fidx == 6, "R11", "word bytes taken", fidx, 6);
    chk(min_gap >= 2, "R9", "min cs high cycles", min_gap, 2);
  endtask

  task automatic t_reject(input logic [1:0] m, input logic [15:0] l, input string what);
    clear(0, 0);
    @(negedge clk); start = 1'b1; op_sel = m; addr = 24'h000200; len = l;
    @(negedge clk); start = 1'b0;
    chk(done && err, "R10", what, {done, err}, 2'b11);
    repeat (40) @(negedge clk);
    chk(nlog == 0 && spi_cs_n, "R10", {what, " frames"}, nlog, 0);
  endtask

  initial begin
    t_reset();
    t_erase_big();
    t_erase_multi();
    t_page();
    t_page_exact();
    t_word();
    t_reject(2'd0, 16'd0, "zero length");
    t_reject(2'd3, 16'd5, "odd word length");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule